// File: doc/BRIEF.md
# MDIO Management Master with Link Autopoll

This block is a management-bus master for an external Ethernet PHY. Software reaches it through a small register port holding two words. The command word packs the transaction fields, and the second word holds the PHY address and a poll interval. The block drives the management clock (MDC) and the data line (MDIO) as an output value with an output enable, and it reads back the line on a separate input. It sends Clause 22 frames only.

Software sets the start bit to launch one read or write. While the frame runs, both start and busy read as 1, and they clear together when the frame ends. After a read, the 16 bits received from the PHY sit in the data field.

When autopoll is enabled, the block owns the bus. At a programmable interval it reads PHY register 1 and tracks bit 2 of that register, the link-status bit. The interrupt output rises when that bit differs from the stored value. Turning autopoll off does not cut short a poll already on the wire: busy stays high until that frame has finished.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, both readback words are zero, and mdc, mdio_oe and irq are low.
- R2: A write sends these fields on MDIO, one per rising MDC edge: 32 one-bits, start 01, opcode 01, the 5-bit PHY address from word 1 bits [20:16], the 5-bit register from command bits [20:16], turnaround 10, and the 16 data bits from command bits [15:0], MSB first.
- R3: A read (command bit 21 = 1) sends the preamble, 01, opcode 10, the PHY address and the register address. It then releases MDIO (mdio_oe low) for the two turnaround bits and the 16 data bits. It samples the data bits on rising MDC, MSB first, and places the value in command bits [15:0] when the frame ends.
- R4: With command bit 22 set, the 32 leading one-bits are left out.
- R5: The clock-select field (command bits [26:24]) sets the MDC period. Code c from 0 to 6 gives 4*(c+1) clock cycles, and code 7 gives 28. MDC is high for the second half of each period and is low when idle.
- R6: Command bit 23 (start) and bit 27 (busy) read 1 from the write that launches a frame until the frame ends, and then both read 0.
- R7: A command write while busy cannot start a frame and does not change the data, register, direction, preamble or clock-select fields. Only autopoll enable and the interrupt clear take effect.
- R8: When command bit 28 (autopoll) is set and the block is idle, a read of register 1 at the programmed PHY address starts once the count set in word 1 bits [15:0] has expired. Busy is high during this frame and start stays 0.
- R9: When an autopoll read ends, received bit 2 is stored as the link state (command bit 29, 0 after reset). If that bit differs from the stored value, irq and command bit 31 go high. They stay high until a command write with bit 31 set.
- R10: Clearing autopoll during a poll leaves busy high until that frame ends. A software start after that is accepted.
- R11: While a frame runs, mdio_o and mdio_oe change only in the cycle where MDC falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wsel | input | 1 | Write target: 0 command, 1 PHY address/interval |
| reg_wdata | input | 32 | Write data |
| reg_rsel | input | 1 | Read select: 0 command, 1 PHY address/interval |
| reg_rdata | output | 32 | Read data of the selected word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value seen on the line |
| irq | output | 1 | Link-change interrupt level |

## Verification
On every cycle, the assertions check four things:
- start never reads 1 without busy;
- an autopoll frame never shows start;
- a write during busy leaves the frame fields alone;
- the interrupt holds until cleared, and the MDC counter stays in range.

They also check that MDIO moves only on falling MDC. The bench scenarios cover the rest:
- exact frame contents and MDC period for each divider code, with and without preamble;
- capture of read data from a modelled PHY;
- the autopoll interval, link compare and drain-then-start sequence.

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
  parameter int IVL_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_wsel,
  input  logic [31:0] reg_wdata,
  input  logic        reg_rsel,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i,
  output logic        irq
);

  logic [15:0] data_r, rx;
  logic [4:0]  regad_r, phyad_r, cnt;
  logic [2:0]  csel_r;
  logic        rnw_r, pre_r, start_r, ap_r, irq_r, link_r;
  logic        busy_r, fr_rd, fr_sw;
  logic [31:0] fr_word;
  logic [5:0]  pos;
  logic [3:0]  half_r;
  logic [IVL_W-1:0] ivl_lim_r, ivl_cnt;

  function automatic logic [3:0] half_of(input logic [2:0] sel);
    return (sel == 3'd7) ? 4'd14 : {sel, 1'b0} + 4'd2;
  endfunction

  wire ctl_wr  = reg_wr && !reg_wsel;
  wire phy_wr  = reg_wr && reg_wsel;
  wire sw_go   = ctl_wr && reg_wdata[23] && !busy_r;
  wire ap_go   = ap_r && !busy_r && !ctl_wr && (ivl_cnt >= ivl_lim_r);
  wire bit_end = busy_r && (cnt == {half_r, 1'b0} - 5'd1);
  wire rise    = busy_r && (cnt == {1'b0, half_r} - 5'd1);
  wire in_data = fr_rd && pos[5] && (pos[4:0] >= 5'd16);
  wire cur_bit = pos[5] ? fr_word[~pos[4:0]] : 1'b1;
  wire unused_wd = ^reg_wdata[30:29];

  wire launch_rd = sw_go ? reg_wdata[21] : 1'b1;
  wire [4:0] launch_reg = sw_go ? reg_wdata[20:16] : 5'd1;

  assign mdc     = busy_r && (cnt >= {1'b0, half_r});
  assign mdio_oe = busy_r && !(fr_rd && pos[5] && (pos[4:0] >= 5'd14));
  assign mdio_o  = mdio_oe && cur_bit;
  assign irq     = irq_r;
  assign reg_rdata = reg_rsel ? {11'd0, phyad_r, 16'(ivl_lim_r)}
                              : {irq_r, 1'b0, link_r, ap_r, busy_r, csel_r, start_r,
                                 pre_r, rnw_r, regad_r, data_r};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_r <= '0; regad_r <= '0; rnw_r <= 1'b0; pre_r <= 1'b0; start_r <= 1'b0;
      csel_r <= '0; ap_r <= 1'b0; irq_r <= 1'b0; link_r <= 1'b0;
      phyad_r <= '0; ivl_lim_r <= '0; ivl_cnt <= '0;
      busy_r <= 1'b0; fr_rd <= 1'b0; fr_sw <= 1'b0; fr_word <= '0;
      pos <= '0; cnt <= '0; half_r <= 4'd2; rx <= '0;
    end else begin
      if (ctl_wr) begin
        ap_r <= reg_wdata[28];
        if (reg_wdata[31]) irq_r <= 1'b0;
        if (!busy_r) begin
          data_r  <= reg_wdata[15:0];
          regad_r <= reg_wdata[20:16];
          rnw_r   <= reg_wdata[21];
          pre_r   <= reg_wdata[22];
          start_r <= reg_wdata[23];
          csel_r  <= reg_wdata[26:24];
        end
      end
      if (phy_wr) begin
        phyad_r   <= reg_wdata[20:16];
        ivl_lim_r <= reg_wdata[IVL_W-1:0];
      end
      if (busy_r || !ap_r || ap_go) ivl_cnt <= '0;
      else if (ivl_cnt < ivl_lim_r) ivl_cnt <= ivl_cnt + 1'b1;

      if (sw_go || ap_go) begin
        busy_r  <= 1'b1;
        fr_sw   <= sw_go;
        fr_rd   <= launch_rd;
        half_r  <= half_of(sw_go ? reg_wdata[26:24] : csel_r);
        pos     <= (sw_go ? reg_wdata[22] : pre_r) ? 6'd32 : 6'd0;
        cnt     <= '0;
        fr_word <= {2'b01, launch_rd ? 2'b10 : 2'b01, phyad_r, launch_reg,
                    launch_rd ? 18'h30000 : {2'b10, reg_wdata[15:0]}};
      end else if (busy_r) begin
        if (rise && in_data) rx <= {rx[14:0], mdio_i};
        if (bit_end) begin
          cnt <= '0;
          if (pos == 6'd63) begin
            busy_r <= 1'b0;
            if (fr_sw) begin
              start_r <= 1'b0;
              if (fr_rd) data_r <= rx;
            end else begin
              link_r <= rx[2];
              if (rx[2] != link_r) irq_r <= 1'b1;
            end
          end else begin
            pos <= pos + 6'd1;
          end
        end else begin
          cnt <= cnt + 5'd1;
        end
      end
    end
  end

  AST_START_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_r |-> busy_r); // R6
  AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && ctl_wr |=> $stable(regad_r) && $stable(csel_r) && $stable(rnw_r) && $stable(pre_r)); // R7
  AST_POLL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && !fr_sw |-> !start_r); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    irq_r && !(ctl_wr && reg_wdata[31]) |=> irq_r); // R9
  AST_MDC_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |-> cnt < 5'd28); // R5
  AST_MDIO_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r && $past(busy_r) && !$fell(mdc) |-> $stable(mdio_o) && $stable(mdio_oe)); // R11

endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_wsel = 1'b0, reg_rsel = 1'b0, mdio_i = 1'b1;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, irq;

  mdio_mgmt_master u_dut (.*);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int nbits = 0, last_rise = -1, per = -1, hi = -1, k = 0, viol = 0;
  logic [63:0] cap = '0;
  logic [15:0] phy_val = '0;
  logic prev_mdc = 1'b0, prev_o = 1'b0, prev_oe = 1'b0;

  always @(posedge clk) begin
    #1;
    cyc++;
    if (mdc && !prev_mdc) begin
      if (mdio_oe) begin cap = {cap[62:0], mdio_o}; nbits++; end
      if (last_rise >= 0) per = cyc - last_rise;
      last_rise = cyc;
    end
    if (!mdc && prev_mdc) begin
      hi = cyc - last_rise;
      if (!mdio_oe && k < 18) begin
        mdio_i = (k == 0) ? 1'b1 : (k == 1) ? 1'b0 : phy_val[17-k];
        k++;
      end
    end
    if (mdio_oe) k = 0;
    if (prev_oe && mdio_oe && mdio_o != prev_o && !(prev_mdc && !mdc)) viol++;
    prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_wsel = sel; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rdreg(input logic sel, output logic [31:0] v);
    reg_rsel = sel; #0.5; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 5000 && !done; i++) begin
      @(negedge clk); rdreg(1'b0, v);
      if (!v[27]) done = 1;
    end
    if (!done) chk("R6 busy clears", 1, 0);
  endtask

  task automatic wait_busy();
    logic [31:0] v;
    bit done = 0;
    for (int i = 0; i < 5000 && !done; i++) begin
      @(negedge clk); rdreg(1'b0, v);
      if (v[27]) done = 1;
    end
    if (!done) chk("R8 poll starts", 0, 1);
  endtask

  task automatic txn(input logic rnw, input logic pre, input logic [2:0] cs,
                     input logic [4:0] phy, input logic [4:0] ra, input logic [15:0] d);
    logic [31:0] w, v;
    logic [63:0] exp;
    logic [13:0] hdr;
    int div;
    div = (cs == 3'd7) ? 28 : 4 * (int'(cs) + 1);
    hdr = {2'b01, rnw ? 2'b10 : 2'b01, phy, ra};
    if (rnw) exp = pre ? {50'd0, hdr} : {18'd0, 32'hFFFF_FFFF, hdr};
    else exp = pre ? {32'd0, hdr, 2'b10, d} : {32'hFFFF_FFFF, hdr, 2'b10, d};
    w = '0; w[15:0] = d; w[20:16] = ra; w[21] = rnw; w[22] = pre; w[23] = 1'b1; w[26:24] = cs;
    nbits = 0; cap = '0;
    wr(1'b0, w);
    rdreg(1'b0, v);
    chk("R6 start set", v[23], 1);
    chk("R6 busy set", v[27], 1);
    wait_idle();
    rdreg(1'b0, v);
    chk("R6 start cleared", v[23], 0);
    chk(rnw ? "R3 frame bits" : (pre ? "R4 short frame bits" : "R2 frame bits"), cap, exp);
    chk("R4 driven bit count", nbits, rnw ? (pre ? 14 : 46) : (pre ? 32 : 64));
    chk("R5 mdc period", per, div);
    chk("R5 mdc high time", hi, div / 2);
    chk(rnw ? "R3 captured data" : "R2 data kept", v[15:0], rnw ? phy_val : d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rdreg(1'b0, v); chk("R1 command reset", v, 0);
    rdreg(1'b1, v); chk("R1 phy word reset", v, 0);
    chk("R1 pins reset", {mdc, mdio_oe, irq}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 8; c++) begin
      logic [4:0] phy;
      phy = 5'(c * 4 + 1);
      wr(1'b1, {11'd0, phy, 16'd0});
      txn(1'b0, c[0], 3'(c), phy, 5'(c * 3 + 1), 16'hA5C3 ^ 16'(c * 16'h1111));
      phy_val = 16'h1234 + 16'(c * 16'h0F0F);
      txn(1'b1, ~c[0], 3'(c), phy, 5'(31 - c), 16'h0);
    end

    // R7: second start while busy is dropped
    nbits = 0; cap = '0;
    wr(1'b1, {11'd0, 5'd9, 16'd0});
    wr(1'b0, {5'd0, 3'd0, 1'b1, 1'b0, 1'b0, 5'd3, 16'hBEEF});
    wr(1'b0, {5'd0, 3'd3, 1'b1, 1'b1, 1'b1, 5'd7, 16'h0F0F});
    wait_idle();
    rdreg(1'b0, v);
    chk("R7 single frame", nbits, 64);
    chk("R7 frame unchanged", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd9, 5'd3, 2'b10, 16'hBEEF});
    chk("R7 fields unchanged", v[26:16], {3'd0, 1'b0, 1'b0, 1'b0, 5'd3});

    // R8/R9/R10: autopoll with link up
    wr(1'b1, {11'd0, 5'd5, 16'd40});
    phy_val = 16'h0004; nbits = 0; cap = '0;
    wr(1'b0, 32'h1000_0000);
    wait_busy();
    rdreg(1'b0, v);
    chk("R8 poll keeps start low", v[23], 0);
    wr(1'b0, 32'h0);
    rdreg(1'b0, v);
    chk("R10 busy held after disable", {v[28], v[27]}, 2'b01);
    wait_idle();
    chk("R8 poll frame", cap, {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'd5, 5'd1});
    rdreg(1'b0, v);
    chk("R9 irq on link change", {irq, v[31], v[29]}, 3'b111);
    txn(1'b0, 1'b1, 3'd1, 5'd5, 5'd4, 16'h55AA); // R10 start accepted after drain
    chk("R9 irq held", irq, 1);
    wr(1'b0, 32'h8000_0000);
    chk("R9 irq cleared", irq, 0);

    // R9: same link state, no interrupt
    wr(1'b0, 32'h1000_0000);
    wait_busy(); wait_idle();
    wr(1'b0, 32'h0);
    wait_idle();
    chk("R9 no change no irq", irq, 0);

    // R9: link drops
    phy_val = 16'hFFFB;
    wr(1'b0, 32'h1000_0000);
    wait_busy(); wait_idle();
    wr(1'b0, 32'h0);
    wait_idle();
    rdreg(1'b0, v);
    chk("R9 irq on link drop", {irq, v[29]}, 2'b10);

    chk("R11 mdio moves only on falling mdc", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule